// File: doc/BRIEF.md
# Serial Audio Output Port

This block sends a stereo pair of audio words over a four-wire serial link. The link has a bit clock, a frame clock that tells left from right, a word clock that marks the start of a field, and one data line. Both clocks come from outside the block. The block samples them in its own system clock domain and finds their edges there. On each launch edge of the bit clock it drives the next data bit. The launch edge is the bit clock edge opposite to the one on which the receiver samples.

A field is the serial word for one channel. It is a fixed 24 bits, most significant bit first, and zeros follow it until the next field begins. A receiver can therefore keep as many leading bits as it needs. Three static settings shape the framing. The first picks which clock marks a field: the frame clock or the word clock. The second chooses whether the MSB goes out on the marking bit slot or one slot later. The third chooses which bit clock edge the receiver samples on. A mute request turns a whole frame into zeros. Both channel words and the mute request are captured together when a left field begins, so neither a word update nor a mute change can split a frame.

Top module: `sao_tx`

## Requirements
- R1: Each field carries its word most significant bit first, one bit per bit slot. The bits follow one another with no gap.
- R2: After the 24th bit of a field, the data line stays at zero until the next field begins.
- R3: With `cfg_word_ref`=0, any change of level on `frame_clk` seen at a launch edge starts a field. `frame_clk`=1 selects the left word and `frame_clk`=0 selects the right word. `word_clk` has no effect in this setting.
- R4: With `cfg_word_ref`=1, a rising edge of `word_clk` seen at a launch edge starts a field, and the level of `frame_clk` at that slot picks the channel. A change on `frame_clk` in the middle of a field has no effect.
- R5: With `cfg_delay`=0, the MSB goes out in the bit slot that starts the field. With `cfg_delay`=1, it goes out in the following slot.
- R6: With `cfg_fall`=0, data changes only after a falling edge of `bclk` and is stable at the rising edge. With `cfg_fall`=1, the two edges swap roles.
- R7: Both `left_word` and `right_word` are captured when a left field starts, that is, in the slot that sends its MSB. Input changes after that point do not reach the output until the next left field.
- R8: `mute` is sampled when a left field starts. A frame sampled as muted sends all zeros in both fields, and a mute change in the middle of a frame takes effect from the next frame.
- R9: Under reset, `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial-side inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Serial bit clock |
| frame_clk | input | 1 | Channel clock: 1 selects left, 0 selects right |
| word_clk | input | 1 | Field-start clock, used when `cfg_word_ref`=1 |
| cfg_word_ref | input | 1 | 0 = fields marked by `frame_clk`, 1 = fields marked by the rising edge of `word_clk` |
| cfg_delay | input | 1 | 1 = MSB one bit slot after the marking slot |
| cfg_fall | input | 1 | 0 = receiver samples on the rising edge of `bclk`, 1 = on the falling edge |
| mute | input | 1 | Mute request, applied per frame |
| left_word | input | 24 | Left channel sample |
| right_word | input | 24 | Right channel sample |
| sdata | output | 1 | Serial data out |

## Verification
The start of a left field is the slot where three things meet: the two words are captured, mute is sampled, and the first bit goes out. The bench changes both words, and sometimes the mute input, in the middle of the right field of every frame. Each such change must leave the current frame's remaining bits unchanged and show up only from the next frame. With a one-slot delay, the slot that marks a new field also carries the zero tail of the previous field, so the tail and the new field's MSB fall in neighbouring slots. Random field lengths from exactly 24 up to 34 slots, in all eight settings, place the tail, the MSB and the capture right next to one another, and a bench model of a receiver judges every sampled bit.

// File: rtl/sao_pkg.sv
package sao_pkg;

   typedef enum logic {
      SAO_REF_FRAME = 1'b0,
      SAO_REF_WORD  = 1'b1
   } sao_ref_e;

   typedef struct packed {
      sao_ref_e ref_sel;
      logic     delay_en;
      logic     sample_fall;
   } sao_cfg_t;

endpackage

// File: rtl/sao_sync.sv
module sao_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1)  begin : g_bad_width  $error("sao_sync: WIDTH must be at least 1");  end
   if (STAGES < 1) begin : g_bad_stages $error("sao_sync: STAGES must be at least 1"); end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sao_framer.sv
module sao_framer
   import sao_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  sao_cfg_t cfg_i,
   input  logic     bclk_i,
   input  logic     lr_i,
   input  logic     wc_i,
   output logic     launch_o,
   output logic     load_o,
   output logic     load_left_o,
   output logic     shift_o
);

   logic bclk_q;
   logic lr_last_q;
   logic wc_last_q;
   logic pend_q;
   logic pend_left_q;
   logic start;

   // launch edge is the one opposite to the receiver's sampling edge
   always_comb begin
      if (cfg_i.sample_fall) launch_o = bclk_i & ~bclk_q;
      else                   launch_o = ~bclk_i & bclk_q;
   end

   always_comb begin
      if (cfg_i.ref_sel == SAO_REF_WORD) start = launch_o & wc_i & ~wc_last_q;
      else                               start = launch_o & (lr_i ^ lr_last_q);
   end

   always_comb begin
      load_o      = launch_o & (pend_q | (start & ~cfg_i.delay_en));
      load_left_o = pend_q ? pend_left_q : lr_i;
      shift_o     = launch_o & ~load_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q      <= 1'b0;
         lr_last_q   <= 1'b0;
         wc_last_q   <= 1'b0;
         pend_q      <= 1'b0;
         pend_left_q <= 1'b0;
      end else begin
         bclk_q <= bclk_i;
         if (launch_o) begin
            lr_last_q   <= lr_i;
            wc_last_q   <= wc_i;
            pend_q      <= start & cfg_i.delay_en;
            pend_left_q <= lr_i;
         end
      end
   end

   // R5: a delayed start arms exactly one pending load for the next launch
   p_delay_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cfg_i.delay_en) |=> (pend_q && !load_o));

   // R3: in frame-clock mode an undelayed level change loads the matching channel at once
   p_frame_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i.ref_sel == SAO_REF_FRAME && !cfg_i.delay_en && !pend_q && launch_o && (lr_i != lr_last_q))
      |-> (load_o && (load_left_o == lr_i)));

endmodule

// File: rtl/sao_shifter.sv
module sao_shifter #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              load_left_i,
   input  logic              shift_i,
   input  logic              mute_i,
   input  logic [WORD_W-1:0] left_word_i,
   input  logic [WORD_W-1:0] right_word_i,
   output logic              sdata_o
);

   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   if (WORD_W < 2) begin : g_bad_word $error("sao_shifter: WORD_W must be at least 2"); end

   logic [WORD_W-1:0] right_hold_q;
   logic [WORD_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              mute_q;
   logic [WORD_W-1:0] next_word;

   always_comb begin
      if (load_left_i) next_word = mute_i ? '0 : left_word_i;
      else             next_word = mute_q ? '0 : right_hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         right_hold_q <= '0;
         sr_q         <= '0;
         cnt_q        <= '0;
         mute_q       <= 1'b0;
         sdata_o      <= 1'b0;
      end else if (load_i) begin
         if (load_left_i) begin
            mute_q       <= mute_i;
            right_hold_q <= right_word_i;
         end
         sdata_o <= next_word[WORD_W-1];
         sr_q    <= {next_word[WORD_W-2:0], 1'b0};
         cnt_q   <= CNT_W'(1);
      end else if (shift_i) begin
         sdata_o <= sr_q[WORD_W-1];
         sr_q    <= {sr_q[WORD_W-2:0], 1'b0};
         if (cnt_q <= CNT_FULL) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R1: left field opens with the MSB of the word present at the port
   p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_left_i && !mute_i) |=> (sdata_o == $past(left_word_i[WORD_W-1])));

   // R2: once the full word has gone out, further slots carry zero
   p_zero_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && cnt_q >= CNT_FULL) |=> !sdata_o);

   // R6: the data line moves only on launch slots
   p_launch_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i || shift_i) |=> $stable(sdata_o));

   // R8: a muted frame starts and continues with zeros
   p_mute_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_left_i && mute_i) |=> !sdata_o);
   p_mute_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !load_left_i && mute_q) |=> !sdata_o);

endmodule

// File: rtl/sao_tx.sv
module sao_tx
   import sao_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              frame_clk,
   input  logic              word_clk,
   input  logic              cfg_word_ref,
   input  logic              cfg_delay,
   input  logic              cfg_fall,
   input  logic              mute,
   input  logic [WORD_W-1:0] left_word,
   input  logic [WORD_W-1:0] right_word,
   output logic              sdata
);

   localparam int SER_W = 3;

   if (SYNC_STAGES < 1) begin : g_bad_sync $error("sao_tx: SYNC_STAGES must be at least 1"); end

   sao_cfg_t         cfg;
   logic [SER_W-1:0] ser_raw;
   logic [SER_W-1:0] ser_s;
   logic             launch;
   logic             load;
   logic             load_left;
   logic             shift;

   assign cfg.ref_sel     = cfg_word_ref ? SAO_REF_WORD : SAO_REF_FRAME;
   assign cfg.delay_en    = cfg_delay;
   assign cfg.sample_fall = cfg_fall;
   assign ser_raw         = {bclk, frame_clk, word_clk};

   sao_sync #(.WIDTH(SER_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ser_raw),
      .q_o   (ser_s)
   );

   sao_framer u_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_i       (cfg),
      .bclk_i      (ser_s[2]),
      .lr_i        (ser_s[1]),
      .wc_i        (ser_s[0]),
      .launch_o    (launch),
      .load_o      (load),
      .load_left_o (load_left),
      .shift_o     (shift)
   );

   sao_shifter #(.WORD_W(WORD_W)) u_shifter (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .load_left_i  (load_left),
      .shift_i      (shift),
      .mute_i       (mute),
      .left_word_i  (left_word),
      .right_word_i (right_word),
      .sdata_o      (sdata)
   );

   // R6: every data step is tied to a launch edge
   p_step_on_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load, shift}) && ((load || shift) == launch));

endmodule

// File: tb/test_sao_tx.sv
module test_sao_tx;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_SLOT  = 6;
   localparam int W          = 24;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         bclk, frame_clk, word_clk;
   logic         cfg_word_ref, cfg_delay, cfg_fall;
   logic         mute;
   logic [W-1:0] left_word, right_word;
   logic         sdata;

   int  vectors = 0;
   int  errors  = 0;
   bit  done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sao_tx i_sao_tx (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .frame_clk(frame_clk), .word_clk(word_clk),
      .cfg_word_ref(cfg_word_ref), .cfg_delay(cfg_delay), .cfg_fall(cfg_fall),
      .mute(mute), .left_word(left_word), .right_word(right_word), .sdata(sdata)
   );

   task automatic check(input bit got, input bit exp, input string tag, input string where);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b", tag, where, got, exp);
      end
   endtask

   function automatic bit exp_bit(input logic [W-1:0] w, input int idx);
      if (idx < 0 || idx >= W) return 1'b0;
      return w[W-1-idx];
   endfunction

   function automatic string tag_of(input bit left, input bit muted, input int idx, input bit dly);
      if (muted)                 return "R8";
      if (idx < 0 || idx >= W)   return "R2";
      if (dly && idx == 0)       return "R5";
      if (!left)                 return "R7";
      return "R1";
   endfunction

   task automatic do_reset(input bit ref_sel, input bit dly, input bit fall);
      @(negedge clk);
      rst_n        = 1'b0;
      cfg_word_ref = ref_sel;
      cfg_delay    = dly;
      cfg_fall     = fall;
      bclk         = ~fall;   // rest at the sampling-edge level
      frame_clk    = 1'b0;
      word_clk     = 1'b0;
      mute         = 1'b0;
      repeat (3) @(negedge clk);
      check(sdata, 1'b0, "R9", "reset value");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(sdata, 1'b0, "R9", "after reset");
   endtask

   // one field: ref R3 (frame clock) or R4 (word clock), delay R5, edge R6
   task automatic run_field(input bit left, input int nslots, input logic [W-1:0] w, input bit muted);
      for (int k = 0; k < nslots; k++) begin
         bclk      = cfg_fall;             // launch edge
         frame_clk = left;
         if (cfg_word_ref) begin
            word_clk = (k == 0);
            if (k >= 10 && k <= 11) frame_clk = ~left;   // R4 mid-field frame clock noise
         end else begin
            word_clk = 1'($urandom_range(0, 1));          // R3 word clock ignored
         end
         if (!left && k == 3) begin
            left_word  = W'($urandom);
            right_word = W'($urandom);
            mute       = ($urandom_range(0, 3) == 0);
         end
         repeat (HALF_SLOT) @(negedge clk);
         begin
            int idx;
            idx = k - int'(cfg_delay);
            check(sdata, muted ? 1'b0 : exp_bit(w, idx),
                  tag_of(left, muted, idx, cfg_delay),
                  $sformatf("ref=%0d dly=%0d fall=%0d %s slot %0d", cfg_word_ref, cfg_delay,
                            cfg_fall, left ? "L" : "R", k));
         end
         bclk = ~cfg_fall;                 // sampling edge (R6)
         repeat (HALF_SLOT) @(negedge clk);
      end
   endtask

   task automatic run_frame();
      logic [W-1:0] cap_l, cap_r;
      bit cap_m;
      int n_l, n_r;
      cap_l = left_word;
      cap_r = right_word;
      cap_m = mute;
      n_l = cfg_delay ? 25 + $urandom_range(0, 9) : 24 + $urandom_range(0, 10);
      n_r = cfg_delay ? 25 + $urandom_range(0, 9) : 24 + $urandom_range(0, 10);
      run_field(1'b1, n_l, cap_l, cap_m);
      run_field(1'b0, n_r, cap_r, cap_m);
   endtask

   initial begin
      void'($urandom(32'd1890));
      rst_n = 1'b0; bclk = 1'b1; frame_clk = 1'b0; word_clk = 1'b0;
      cfg_word_ref = 1'b0; cfg_delay = 1'b0; cfg_fall = 1'b0; mute = 1'b0;
      left_word = '0; right_word = '0;
      for (int c = 0; c < 8; c++) begin
         do_reset(c[0], c[1], c[2]);
         // directed corners: all ones, then a single LSB, then random frames
         left_word = '1; right_word = W'(1); mute = 1'b0;
         run_frame();
         for (int f = 0; f < 4; f++) run_frame();
         // directed R8: mute raised before a left start silences the whole frame
         mute = 1'b1; left_word = '1; right_word = '1;
         run_frame();
         mute = 1'b0;
         run_frame();
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule